// File: doc/BRIEF.md
# Half-Bridge Pair Gate Control

This block holds the switching logic for two independent half-bridges, called leg A and leg B. Each leg has a low-side and a high-side command bit and drives two gate-enable outputs. A low-side command that is high always wins over the high-side command of the same leg, so the two switches of a leg can never both be commanded on. Every turn-on waits for a programmable dead time, counted in clock cycles. There is one dead time for the high switches and one for the low switches. Every turn-off takes effect at once.

A shared disable input and a shared undervoltage flag each force all four enables low. When both are low again, a release sequence runs. First both low switches turn on for a refresh window, which recharges the bootstrap capacitors. The high switches stay blocked until a longer upper-enable delay has passed since the release. All six command and protection inputs are asynchronous and pass through two-flop synchronizers. The two dead-time inputs are quasi-static settings and must only change while no dead-time count is running.

Bistate operation needs no separate mode pin. The high-side command is held at 1, and the low-side command alone switches the leg. The low switch follows that command and the high switch takes its complement, with a dead time on each change. The parameters must satisfy UPEN_CYC > REFRESH_CYC + (largest high-side dead time used).

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While rst_n is low, all four enable outputs are 0.
- R2: Once disable has been high for two clocks, all four enables are 0 from the third rising edge after disable rises. While disable stays high, the command inputs have no effect on any output.
- R3: The undervoltage flag forces all four enables to 0 in the same way and with the same latency as disable.
- R4: In each leg, a low-side command of 1 turns the low enable on and holds the high enable at 0, whatever the high-side command is.
- R5: In each leg, command pair (low=0, high=1) gives high enable 1 and low enable 0, and (0,0) gives both enables 0. Legs A and B respond only to their own commands.
- R6: Turn-off is immediate. An enable falls at the third rising edge after its command is withdrawn (two synchronizer stages plus the output register).
- R7: Turn-on is delayed. From idle, an enable rises at rising edge 3+dt after its command is applied. After the opposite switch of the leg turns off, the leg stays with both enables low for exactly dt+1 cycles before the new switch turns on. This holds for dt=0. Here dt means dt_hi for a high switch and dt_lo for a low switch.
- R8: The two enables of one leg are never high together. An enable rises only if the other enable of its leg was low in the cycle before.
- R9: In bistate use (high command held at 1), the low enable follows the low command and the high enable is its complement. The R7 dead time applies to every change.
- R10: After disable and undervoltage are both released, both low enables turn on for REFRESH_CYC − dt_lo cycles even with every low command at 0. No high enable turns on during this window.
- R11: High enables stay 0 until UPEN_CYC cycles after the release. With leg commands (0,1), the high enable rises exactly UPEN_CYC + dt_hi − REFRESH_CYC cycles after the refresh window ends.
- R12: If disable or undervoltage is reasserted during a refresh, the enables turn off with R6 latency. The next release runs the full refresh window again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_lo_cmd | input | 1 | Leg A low-side command (async) |
| a_hi_cmd | input | 1 | Leg A high-side command (async) |
| b_lo_cmd | input | 1 | Leg B low-side command (async) |
| b_hi_cmd | input | 1 | Leg B high-side command (async) |
| dis | input | 1 | Disable, forces all enables low (async) |
| uv | input | 1 | Undervoltage flag, forces all enables low (async) |
| dt_hi | input | DT_W | High-side turn-on dead time in cycles |
| dt_lo | input | DT_W | Low-side turn-on dead time in cycles |
| a_lo_en | output | 1 | Leg A low switch enable |
| a_hi_en | output | 1 | Leg A high switch enable |
| b_lo_en | output | 1 | Leg B low switch enable |
| b_hi_en | output | 1 | Leg B high switch enable |

## Verification
The bound checker enforces the leg safety rules on every cycle. These are: no overlap within a leg, and break-before-make. It also checks that synchronized disable and undervoltage clear all enables on the next edge, that a low command blocks the high enable, that a withdrawn command drops its enable at once, and that high enables stay off while the upper-enable delay is pending. Some behaviour can only be shown by the directed scenarios, because it depends on windows measured from input changes. This covers exact dead-time gap lengths, the synchronizer latency, the refresh pulse width, the refresh-to-high-side gap, and the restart after an aborted refresh.

// File: rtl/bridge_gate_pkg.sv
`timescale 1ns/1ps
package bridge_gate_pkg;
  localparam int LEGS = 2;
  localparam int SYNC_BITS = 6;
  typedef struct packed {
    logic uv;
    logic dis;
    logic b_hi;
    logic b_lo;
    logic a_hi;
    logic a_lo;
  } raw_in_t;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/deadtime_gate.sv
`timescale 1ns/1ps
module deadtime_gate #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic            other_on,
  input  logic [DT_W-1:0] dt,
  output logic            en
);
  logic [DT_W-1:0] cnt;

  // turn-off is immediate; turn-on waits dt cycles with the partner off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (!want || other_on) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (!en) begin
      if (cnt >= dt) en  <= 1'b1;
      else           cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/half_leg.sv
`timescale 1ns/1ps
module half_leg #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_cmd,
  input  logic            hi_cmd,
  input  logic            kill,
  input  logic            refresh_on,
  input  logic            hi_allow,
  input  logic [DT_W-1:0] dt_lo,
  input  logic [DT_W-1:0] dt_hi,
  output logic            lo_en,
  output logic            hi_en
);
  logic want_lo, want_hi;

  always_comb begin
    want_lo = !kill && (refresh_on || lo_cmd);
    want_hi = !kill && !refresh_on && hi_allow && hi_cmd && !lo_cmd;
  end

  deadtime_gate #(.DT_W(DT_W)) lo_gate_i (
    .clk(clk), .rst_n(rst_n), .want(want_lo), .other_on(hi_en),
    .dt(dt_lo), .en(lo_en));

  deadtime_gate #(.DT_W(DT_W)) hi_gate_i (
    .clk(clk), .rst_n(rst_n), .want(want_hi), .other_on(lo_en),
    .dt(dt_hi), .en(hi_en));
endmodule

// File: rtl/release_seq.sv
`timescale 1ns/1ps
module release_seq #(
  parameter int REFRESH_CYC = 24,
  parameter int UPEN_CYC    = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  output logic refresh_on,
  output logic hi_allow
);
  localparam int REL_W = $clog2(UPEN_CYC + 1);
  localparam logic [REL_W-1:0] REF_LIM = REL_W'(REFRESH_CYC);
  localparam logic [REL_W-1:0] UP_LIM  = REL_W'(UPEN_CYC);

  logic [REL_W-1:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rel_cnt <= '0;
    else if (kill)             rel_cnt <= '0;
    else if (rel_cnt != UP_LIM) rel_cnt <= rel_cnt + 1'b1;
  end

  always_comb begin
    refresh_on = !kill && (rel_cnt < REF_LIM);
    hi_allow   = !kill && (rel_cnt == UP_LIM);
  end
endmodule

// File: rtl/bridge_gate_ctrl.sv
`timescale 1ns/1ps
module bridge_gate_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int DT_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REFRESH_CYC = 24,
  parameter int UPEN_CYC    = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_lo_cmd,
  input  logic            a_hi_cmd,
  input  logic            b_lo_cmd,
  input  logic            b_hi_cmd,
  input  logic            dis,
  input  logic            uv,
  input  logic [DT_W-1:0] dt_hi,
  input  logic [DT_W-1:0] dt_lo,
  output logic            a_lo_en,
  output logic            a_hi_en,
  output logic            b_lo_en,
  output logic            b_hi_en
);
  raw_in_t raw_in, syn_in;
  logic [LEGS-1:0] lo_s, hi_s, lo_en, hi_en;
  logic dis_s, uv_s, kill, refresh_on, hi_allow;

  assign raw_in = '{uv: uv, dis: dis, b_hi: b_hi_cmd, b_lo: b_lo_cmd,
                    a_hi: a_hi_cmd, a_lo: a_lo_cmd};

  bit_sync #(.W(SYNC_BITS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

  assign dis_s = syn_in.dis;
  assign uv_s  = syn_in.uv;
  assign kill  = dis_s | uv_s;
  assign lo_s  = {syn_in.b_lo, syn_in.a_lo};
  assign hi_s  = {syn_in.b_hi, syn_in.a_hi};

  release_seq #(.REFRESH_CYC(REFRESH_CYC), .UPEN_CYC(UPEN_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .kill(kill),
    .refresh_on(refresh_on), .hi_allow(hi_allow));

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    half_leg #(.DT_W(DT_W)) leg_i (
      .clk(clk), .rst_n(rst_n), .lo_cmd(lo_s[g]), .hi_cmd(hi_s[g]),
      .kill(kill), .refresh_on(refresh_on), .hi_allow(hi_allow),
      .dt_lo(dt_lo), .dt_hi(dt_hi), .lo_en(lo_en[g]), .hi_en(hi_en[g]));
  end

  assign a_lo_en = lo_en[0];
  assign a_hi_en = hi_en[0];
  assign b_lo_en = lo_en[1];
  assign b_hi_en = hi_en[1];
endmodule

// File: rtl/bridge_gate_ctrl_chk.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dis_s,
  input logic       uv_s,
  input logic [1:0] lo_s,
  input logic [1:0] hi_s,
  input logic       refresh_on,
  input logic       hi_allow,
  input logic       a_lo_en,
  input logic       a_hi_en,
  input logic       b_lo_en,
  input logic       b_hi_en
);
  assert_dis_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_s |=> !(a_lo_en || a_hi_en || b_lo_en || b_hi_en));

  assert_uv_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> !(a_lo_en || a_hi_en || b_lo_en || b_hi_en));

  assert_lo_wins_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_s[0] |=> !a_hi_en);
  assert_lo_wins_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_s[1] |=> !b_hi_en);

  assert_lo_off_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_s[0] && !refresh_on) |=> !a_lo_en);
  assert_hi_off_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_s[1] |=> !b_hi_en);

  assert_no_overlap_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_lo_en && a_hi_en));
  assert_no_overlap_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_lo_en && b_hi_en));
  assert_bbm_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_hi_en) |-> !$past(a_lo_en));
  assert_bbm_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_lo_en) |-> !$past(b_hi_en));

  assert_hi_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_allow |=> !(a_hi_en || b_hi_en));
endmodule

bind bridge_gate_ctrl bridge_gate_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dis_s(dis_s), .uv_s(uv_s),
  .lo_s(lo_s), .hi_s(hi_s), .refresh_on(refresh_on), .hi_allow(hi_allow),
  .a_lo_en(a_lo_en), .a_hi_en(a_hi_en), .b_lo_en(b_lo_en), .b_hi_en(b_hi_en));

// File: tb/bridge_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_tb_top;
  localparam int DT_W = 4;
  localparam int REF  = 24;
  localparam int UPEN = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_lo_cmd = 0, a_hi_cmd = 0, b_lo_cmd = 0, b_hi_cmd = 0;
  logic dis = 0, uv = 0;
  logic [DT_W-1:0] dt_hi = 4'd3, dt_lo = 4'd2;
  logic a_lo_en, a_hi_en, b_lo_en, b_hi_en;
  logic [3:0] outs;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  assign outs = {b_hi_en, b_lo_en, a_hi_en, a_lo_en};

  bridge_gate_ctrl #(.DT_W(DT_W), .REFRESH_CYC(REF), .UPEN_CYC(UPEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_lo_cmd(a_lo_cmd), .a_hi_cmd(a_hi_cmd),
    .b_lo_cmd(b_lo_cmd), .b_hi_cmd(b_hi_cmd), .dis(dis), .uv(uv),
    .dt_hi(dt_hi), .dt_lo(dt_lo), .a_lo_en(a_lo_en), .a_hi_en(a_hi_en),
    .b_lo_en(b_lo_en), .b_hi_en(b_hi_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // edges until outs[idx]==val (called just after a negedge or a sample)
  task automatic edges_until(input int idx, input logic val, output int n);
    n = 0;
    while (outs[idx] !== val && n < 80) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic set_cmds(input logic al, ah, bl, bh);
    @(negedge clk);
    a_lo_cmd = al; a_hi_cmd = ah; b_lo_cmd = bl; b_hi_cmd = bh;
  endtask

  task automatic t_truth();
    set_cmds(1, 1, 0, 1); cycles(20);
    chk("R4 a lo wins", int'(outs[1:0]), 1);
    chk("R5 b hi only", int'(outs[3:2]), 2);
    set_cmds(0, 1, 1, 1); cycles(20);
    chk("R5 a hi only", int'(outs[1:0]), 2);
    chk("R4 b lo wins", int'(outs[3:2]), 1);
    set_cmds(0, 0, 0, 0); cycles(20);
    chk("R5 all idle", int'(outs), 0);
  endtask

  task automatic t_deadtime();
    int n;
    set_cmds(1, 0, 0, 0); cycles(20);
    set_cmds(0, 1, 0, 0);
    edges_until(0, 1'b0, n); chk("R6 lo turn-off edges", n, 3);
    edges_until(1, 1'b1, n); chk("R7 gap to hi on", n, int'(dt_hi) + 1);
    set_cmds(0, 0, 0, 0);
    edges_until(1, 1'b0, n); chk("R6 hi turn-off edges", n, 3);
    cycles(10);
    set_cmds(0, 1, 0, 0);
    edges_until(1, 1'b1, n); chk("R7 idle hi turn-on edges", n, 3 + int'(dt_hi));
    set_cmds(0, 0, 0, 0); cycles(10);
    dt_hi = '0; dt_lo = '0;
    set_cmds(1, 0, 0, 0); cycles(20);
    set_cmds(0, 1, 0, 0);
    edges_until(0, 1'b0, n);
    edges_until(1, 1'b1, n); chk("R7 zero dead time gap", n, 1);
    set_cmds(0, 0, 0, 0); cycles(10);
    dt_hi = 4'd3; dt_lo = 4'd2;
  endtask

  task automatic t_bistate();
    int n;
    set_cmds(0, 0, 0, 1); cycles(20);
    chk("R9 bistate low cmd 0", int'(outs[3:2]), 2);
    for (int k = 0; k < 2; k++) begin
      set_cmds(0, 0, 1, 1);
      edges_until(3, 1'b0, n); chk("R9 hi off edges", n, 3);
      edges_until(2, 1'b1, n); chk("R9 gap to lo on", n, int'(dt_lo) + 1);
      set_cmds(0, 0, 0, 1);
      edges_until(2, 1'b0, n); chk("R9 lo off edges", n, 3);
      edges_until(3, 1'b1, n); chk("R9 gap to hi on", n, int'(dt_hi) + 1);
    end
    set_cmds(0, 0, 0, 0); cycles(10);
  endtask

  task automatic t_kill(input bit use_uv);
    int n, hits;
    set_cmds(1, 0, 0, 1); cycles(20);
    @(negedge clk);
    if (use_uv) uv = 1; else dis = 1;
    edges_until(0, 1'b0, n);
    chk(use_uv ? "R3 uv turn-off edges" : "R2 dis turn-off edges", n, 3);
    chk(use_uv ? "R3 b hi off" : "R2 b hi off", int'(outs[3]), 0);
    hits = 0;
    for (int k = 0; k < 8; k++) begin
      set_cmds(k[0], k[1], k[1], k[2]);
      cycles(6);
      if (outs != 0) hits++;
    end
    chk(use_uv ? "R3 commands ignored" : "R2 commands ignored", hits, 0);
    set_cmds(0, 0, 0, 0);
    @(negedge clk); dis = 0; uv = 0;
    cycles(80);
  endtask

  task automatic t_release();
    int al = 0, bl = 0, bh = 0, ah_pre = 0, last_lo = -1, first_hi = -1;
    set_cmds(0, 1, 0, 0);
    @(negedge clk); dis = 1;
    cycles(10);
    @(negedge clk); dis = 0;
    for (int k = 0; k < 120; k++) begin
      @(posedge clk); #1;
      if (a_lo_en) begin al++; last_lo = k; end
      if (b_lo_en) bl++;
      if (b_hi_en) bh++;
      if (a_hi_en && first_hi < 0) first_hi = k;
      if (a_hi_en && a_lo_en) ah_pre++;
    end
    chk("R10 a refresh width", al, REF - int'(dt_lo));
    chk("R10 b refresh width", bl, REF - int'(dt_lo));
    chk("R10 no hi during refresh", ah_pre, 0);
    chk("R10 b hi stays off", bh, 0);
    chk("R11 refresh to hi gap", first_hi - last_lo - 1, UPEN + int'(dt_hi) - REF);
    chk("R11 hi on after delay", int'(a_hi_en), 1);
    set_cmds(0, 0, 0, 0); cycles(10);
  endtask

  task automatic t_abort();
    int n, cnt = 0;
    @(negedge clk); dis = 1;
    cycles(10);
    @(negedge clk); dis = 0;
    cycles(10);
    chk("R12 refresh running", int'(a_lo_en), 1);
    @(negedge clk); uv = 1;
    edges_until(0, 1'b0, n); chk("R12 abort edges", n, 3);
    cycles(10);
    @(negedge clk); uv = 0;
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); #1;
      if (a_lo_en) cnt++;
    end
    chk("R12 full refresh after abort", cnt, REF - int'(dt_lo));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cycles(5);
    chk("R1 reset outputs", int'(outs), 0);
    @(negedge clk); rst_n = 1;
    cycles(80);
    t_truth();
    t_deadtime();
    t_bistate();
    t_kill(1'b0);
    t_kill(1'b1);
    t_release();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule